// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Indirect and Interrupt Subcycles

This block is the control unit of a small accumulator machine. It runs the classic instruction cycle, one subcycle after another: a fetch, an optional indirect step, an execute step and, when permitted, an interrupt step. Data moves among the program counter, the memory address register, the memory buffer register, the instruction register and the accumulator. All memory traffic goes over one single-port interface with an address, a write-data bus, a read-data bus and separate read and write strobes. The memory returns read data one cycle after the read strobe.

An instruction word is 16 bits. Bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address field. The execute step knows only enough operations to exercise the data flow: load, store, add, interrupt enable, halt and no-operation. When the indirect flag is set, one extra read fetches the operand address before execution. When interrupts are enabled and the request line is high at the end of an instruction, the sequencer writes the return address to a fixed save location and continues at a fixed handler address.

Top module: `icyc_sequencer`

## Requirements
- R1: While reset is low, neither strobe is active and halted is low. After reset, PC is RESET_PC (default 0), interrupts are disabled, the accumulator is 0 and the first memory access is a read at RESET_PC.
- R2: Each fetch reads the word at PC into the instruction register and increments PC by one. Instructions therefore run from consecutive addresses until an interrupt redirects the PC.
- R3: Opcode encoding in bits 14:12 is 0 = load, 1 = store, 2 = add, 3 = enable interrupts, 7 = halt. Codes 4, 5 and 6 do nothing and touch neither the accumulator nor memory.
- R4: With bit 15 clear, bits 11:0 of the instruction are the operand address, and no read occurs between the fetch and the operand access.
- R5: With bit 15 set, exactly one extra read occurs at the address in bits 11:0. Only bits 11:0 of the returned word become the operand address; its upper four bits are ignored.
- R6: Load copies the memory word into the accumulator. Add adds the memory word to the accumulator modulo 2^16. Store writes the accumulator to the operand address.
- R7: Read data is captured in the cycle after the read strobe. The read strobe and the write strobe are never active in the same cycle.
- R8: The interrupt request is examined only at the end of an instruction, and only when interrupt enable is set. When enable is clear, the request has no effect.
- R9: Interrupt entry clears interrupt enable and writes the address of the next instruction (zero-extended) to SAVE_ADDR (default 0x0F0). The next fetch then reads from HANDLER_ADDR (default 0x0C0).
- R10: The enable-interrupts opcode sets interrupt enable. The check that ends this same instruction still uses the previous value, so the earliest interrupt is taken after the following instruction.
- R11: Halt leaves the sequencer idle with halted high. No strobe is issued after that and the request line is ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Level interrupt request |
| mem_rdata | input | 16 | Memory read data, valid the cycle after mem_rd |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_wdata | output | 16 | Memory write data (memory buffer register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| acc | output | 16 | Accumulator contents |
| halted | output | 1 | High in the idle state reached by halt |

## Verification
The hardest situation to reach from the ports is the interrupt entry placed exactly on an instruction boundary. It needs interrupts enabled by an earlier instruction, the request high at the right moment, and the saved return address matching the PC after an arbitrary mix of direct and indirect instructions. The stimulus holds the request high throughout a run, so whether and when the interrupt is taken depends only on where the enable instruction sits. It runs directed programs that place the enable instruction first, plus random programs that mix indirect flags, operand addresses and enable instructions. A bench interpreter predicts the final memory image, the accumulator and the read and write counts.

// File: rtl/icyc_pkg.sv
// Package: shared types for the instruction cycle sequencer.
// Holds the opcode values, the sequencer state encoding and the per-cycle
// control word that the controller hands to the datapath.
package icyc_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_INTEN = 3'd3,
        OP_NOP4  = 3'd4,
        OP_NOP5  = 3'd5,
        OP_NOP6  = 3'd6,
        OP_HALT  = 3'd7
    } opcode_e;

    typedef enum logic [3:0] {
        S_F_MAR,    // fetch: PC -> MAR
        S_F_RD,     // fetch: read strobe, PC + 1
        S_F_CAP,    // fetch: read data -> MBR
        S_F_IR,     // fetch: MBR -> IR, choose indirect or execute
        S_I_MAR,    // indirect: MBR address field -> MAR
        S_I_RD,     // indirect: read strobe
        S_I_CAP,    // indirect: read data -> MBR
        S_E_DEC,    // execute: decode and set up operand access
        S_E_RD,     // execute: operand read strobe
        S_E_CAP,    // execute: read data -> MBR
        S_E_ACC,    // execute: accumulator update
        S_E_WR,     // execute: store write strobe
        S_INT_SAVE, // interrupt: PC -> MBR, save address -> MAR
        S_INT_WR,   // interrupt: write MBR, PC <- handler
        S_HALT      // idle until reset
    } state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_mbr;
        logic mar_from_save;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic mbr_from_pc;
        logic ir_load;
        logic pc_inc;
        logic pc_to_handler;
        logic acc_load;
        logic acc_add;
        logic ie_set;
        logic ie_clr;
        logic rd;
        logic wr;
    } ctrl_t;

endpackage

// File: rtl/icyc_ctrl.sv
// Module: icyc_ctrl
// The state machine that steps through the fetch, indirect, execute and
// interrupt subcycles and emits one control word per cycle.
// Assumes memory read data arrives one cycle after the read strobe and that
// the datapath applies every control bit at the next clock edge.
module icyc_ctrl
    import icyc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mbr_ind,
    input  logic [OP_W-1:0]     ir_op,
    input  logic                ie,
    input  logic                irq,
    output ctrl_t               ctl,
    output state_e              state,
    output logic                halted
);

    state_e st_q, st_d;

    // Where an instruction goes when it ends: interrupt or the next fetch.
    function automatic state_e end_of_instr(input logic en, input logic req);
        return (en && req) ? S_INT_SAVE : S_F_MAR;
    endfunction

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_F_MAR;
        else        st_q <= st_d;
    end

    // Next state and control word for the current subcycle step.
    always_comb begin
        ctl  = '0;
        st_d = st_q;
        unique case (st_q)
            S_F_MAR: begin
                ctl.mar_from_pc = 1'b1;
                st_d = S_F_RD;
            end
            S_F_RD: begin
                ctl.rd     = 1'b1;
                ctl.pc_inc = 1'b1;
                st_d = S_F_CAP;
            end
            S_F_CAP: begin
                ctl.mbr_from_mem = 1'b1;
                st_d = S_F_IR;
            end
            S_F_IR: begin
                ctl.ir_load = 1'b1;
                st_d = mbr_ind ? S_I_MAR : S_E_DEC;
            end
            S_I_MAR: begin
                ctl.mar_from_mbr = 1'b1;
                st_d = S_I_RD;
            end
            S_I_RD: begin
                ctl.rd = 1'b1;
                st_d = S_I_CAP;
            end
            S_I_CAP: begin
                ctl.mbr_from_mem = 1'b1;
                st_d = S_E_DEC;
            end
            S_E_DEC: begin
                unique case (opcode_e'(ir_op))
                    OP_LOAD, OP_ADD: begin
                        ctl.mar_from_mbr = 1'b1;
                        st_d = S_E_RD;
                    end
                    OP_STORE: begin
                        ctl.mar_from_mbr = 1'b1;
                        ctl.mbr_from_acc = 1'b1;
                        st_d = S_E_WR;
                    end
                    OP_INTEN: begin
                        ctl.ie_set = 1'b1;
                        st_d = end_of_instr(ie, irq);
                    end
                    OP_HALT: st_d = S_HALT;
                    default: st_d = end_of_instr(ie, irq);
                endcase
            end
            S_E_RD: begin
                ctl.rd = 1'b1;
                st_d = S_E_CAP;
            end
            S_E_CAP: begin
                ctl.mbr_from_mem = 1'b1;
                st_d = S_E_ACC;
            end
            S_E_ACC: begin
                ctl.acc_load = (opcode_e'(ir_op) == OP_LOAD);
                ctl.acc_add  = (opcode_e'(ir_op) == OP_ADD);
                st_d = end_of_instr(ie, irq);
            end
            S_E_WR: begin
                ctl.wr = 1'b1;
                st_d = end_of_instr(ie, irq);
            end
            S_INT_SAVE: begin
                ctl.mbr_from_pc   = 1'b1;
                ctl.mar_from_save = 1'b1;
                ctl.ie_clr        = 1'b1;
                st_d = S_INT_WR;
            end
            S_INT_WR: begin
                ctl.wr            = 1'b1;
                ctl.pc_to_handler = 1'b1;
                st_d = S_F_MAR;
            end
            default: st_d = S_HALT;
        endcase
    end

    assign state  = st_q;
    assign halted = (st_q == S_HALT);

endmodule

// File: rtl/icyc_datapath.sv
// Module: icyc_datapath
// Register file of the sequencer: PC, MAR, MBR, IR, accumulator and the
// interrupt-enable bit, each loaded under the controller's control word.
// Assumes at most one source is selected per destination register per cycle.
module icyc_datapath
    import icyc_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0F0,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h0C0,
    parameter logic [ADDR_W-1:0] RESET_PC     = 12'h000,
    localparam int               DATA_W       = ADDR_W + OP_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ctrl_t               ctl,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   pc,
    output logic [ADDR_W-1:0]   mar,
    output logic [DATA_W-1:0]   mbr,
    output logic [DATA_W-1:0]   ir,
    output logic [DATA_W-1:0]   acc,
    output logic                ie
);

    localparam int PAD_W = DATA_W - ADDR_W;

    // Program counter: increment during fetch, jump to handler on interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pc <= RESET_PC;
        else if (ctl.pc_to_handler) pc <= HANDLER_ADDR;
        else if (ctl.pc_inc)        pc <= pc + 1'b1;
    end

    // Memory address register: from PC, MBR address field or save location.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mar <= '0;
        else if (ctl.mar_from_pc)   mar <= pc;
        else if (ctl.mar_from_mbr)  mar <= mbr[ADDR_W-1:0];
        else if (ctl.mar_from_save) mar <= SAVE_ADDR;
    end

    // Memory buffer register: from memory, accumulator or PC.
    always_ff @(posedge clk) begin
        if (!rst_n)                mbr <= '0;
        else if (ctl.mbr_from_mem) mbr <= mem_rdata;
        else if (ctl.mbr_from_acc) mbr <= acc;
        else if (ctl.mbr_from_pc)  mbr <= {{PAD_W{1'b0}}, pc};
    end

    // Instruction register: copy of the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n)           ir <= '0;
        else if (ctl.ir_load) ir <= mbr;
    end

    // Accumulator: load or modular add of the MBR operand.
    always_ff @(posedge clk) begin
        if (!rst_n)            acc <= '0;
        else if (ctl.acc_load) acc <= mbr;
        else if (ctl.acc_add)  acc <= acc + mbr;
    end

    // Interrupt enable: clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n)          ie <= 1'b0;
        else if (ctl.ie_clr) ie <= 1'b0;
        else if (ctl.ie_set) ie <= 1'b1;
    end

endmodule

// File: rtl/icyc_sequencer.sv
// Module: icyc_sequencer (top)
// Instruction cycle sequencer of an accumulator machine: controller plus
// register datapath behind one single-port memory interface.
// Assumes a memory whose read data is valid one cycle after mem_rd and
// which writes mem_wdata at mem_addr on a clock edge with mem_wr high.
module icyc_sequencer
    import icyc_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0F0,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h0C0,
    parameter logic [ADDR_W-1:0] RESET_PC     = 12'h000,
    localparam int               DATA_W       = ADDR_W + OP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] acc,
    output logic              halted
);

    ctrl_t             ctl;
    state_e            state;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] ir;
    logic              ie;

    icyc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mbr_ind (mbr[DATA_W-1]),
        .ir_op   (ir[DATA_W-2 -: OP_W]),
        .ie      (ie),
        .irq     (irq),
        .ctl     (ctl),
        .state   (state),
        .halted  (halted)
    );

    icyc_datapath #(
        .ADDR_W       (ADDR_W),
        .SAVE_ADDR    (SAVE_ADDR),
        .HANDLER_ADDR (HANDLER_ADDR),
        .RESET_PC     (RESET_PC)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .acc       (acc),
        .ie        (ie)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;

endmodule

// File: rtl/icyc_checker.sv
// Module: icyc_checker
// Temporal properties of the sequencer, attached to the top by bind.
// Assumes it sees the top's ports plus its state, PC, MBR and enable bit.
module icyc_checker
    import icyc_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0F0,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h0C0,
    localparam int               DATA_W       = ADDR_W + OP_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              halted,
    input state_e            state,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] mbr,
    input logic              ie
);

    // R7: one memory access per cycle
    a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: the capture step takes the word returned for the previous strobe
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_CAP || state == S_I_CAP || state == S_E_CAP)
        |=> (mbr == $past(mem_rdata)));

    // R2: the fetch read step advances the PC by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_RD) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    // R8: interrupt entry only with enable set
    a_r8_entry_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INT_SAVE) |-> ie);

    // R9: entry clears the enable bit
    a_r9_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INT_SAVE) |=> !ie);

    // R9: save write goes to the save location
    a_r9_save_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INT_WR) |-> (mem_wr && mem_addr == SAVE_ADDR));

    // R9: after the save the PC points at the handler
    a_r9_handler_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INT_WR) |=> (pc == HANDLER_ADDR));

    // R11: halt is sticky and silent
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd && !mem_wr));

endmodule

bind icyc_sequencer icyc_checker #(
    .ADDR_W       (ADDR_W),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
) u_icyc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .state     (state),
    .pc        (pc),
    .mbr       (mbr),
    .ie        (ie)
);

// File: tb/icyc_sequencer_bench.sv
`timescale 1ns/1ps
module icyc_sequencer_bench;

    localparam int SAVE = 'h0F0;
    localparam int HNDL = 'h0C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr;
    logic [15:0] acc;
    logic        halted;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [256];
    logic [15:0] mdl [256];
    int          rd_cnt, wr_cnt;
    int          first_rd_addr;
    logic        seen_rd;
    logic        wd_expired = 1'b0;

    always #2.5 clk = ~clk;

    icyc_sequencer u_icyc_sequencer (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .acc(acc), .halted(halted)
    );

    // Memory model: registered read, one cycle of latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    // Bus monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                rd_cnt <= rd_cnt + 1;
                if (!seen_rd) begin
                    first_rd_addr <= int'(mem_addr);
                    seen_rd <= 1'b1;
                end
            end
            if (mem_wr) wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic ind, input logic [2:0] op, input int a);
        return {ind, op, 12'(a)};
    endfunction

    task automatic put(input int a, input logic [15:0] w);
        mem[a] = w;
        mdl[a] = w;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'h0;
            mdl[i] = 16'h0;
        end
    endtask

    // Instruction-level reference model over mdl; returns acc, reads, writes.
    task automatic model(input logic lvl, output logic [15:0] m_acc,
                         output int m_rd, output int m_wr);
        logic [11:0] pc = 12'h0;
        logic        ie = 1'b0;
        logic        old;
        logic [15:0] w;
        logic [11:0] a;
        m_acc = 16'h0; m_rd = 0; m_wr = 0;
        for (int step = 0; step < 2000; step++) begin
            w = mdl[pc[7:0]];
            pc = pc + 12'd1;
            m_rd++;
            a = w[11:0];
            if (w[15]) begin
                a = mdl[a[7:0]][11:0];
                m_rd++;
            end
            if (w[14:12] == 3'd7) break;
            case (w[14:12])
                3'd0: begin m_acc = mdl[a[7:0]]; m_rd++; end
                3'd1: begin mdl[a[7:0]] = m_acc; m_wr++; end
                3'd2: begin m_acc = m_acc + mdl[a[7:0]]; m_rd++; end
                default: ;
            endcase
            old = ie;
            if (w[14:12] == 3'd3) ie = 1'b1;
            if (old && lvl) begin
                mdl[SAVE] = {4'h0, pc};
                m_wr++;
                pc = 12'(HNDL);
                ie = 1'b0;
            end
        end
    endtask

    // Reset, run to halt, compare against the model.
    task automatic run(input string tag, input logic lvl);
        logic [15:0] e_acc;
        int e_rd, e_wr, cyc, bad_idx, r0, w0;
        model(lvl, e_acc, e_rd, e_wr);
        @(negedge clk);
        rst_n = 1'b0;
        irq = lvl;
        repeat (3) @(negedge clk);
        check({tag, " R1 reset strobes"}, !mem_rd && !mem_wr && !halted,
              {mem_rd, mem_wr, halted}, 0);
        rd_cnt = 0; wr_cnt = 0; seen_rd = 1'b0; first_rd_addr = -1;
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) wd_expired = 1'b1;
        check({tag, " R11 reached halt"}, halted, halted, 1);
        check({tag, " R1 first fetch address"}, first_rd_addr == 0, first_rd_addr, 0);
        check({tag, " R6 accumulator"}, acc == e_acc, acc, e_acc);
        bad_idx = -1;
        for (int i = 0; i < 256; i++) if (bad_idx < 0 && mem[i] !== mdl[i]) bad_idx = i;
        check({tag, " R2/R6 memory image"}, bad_idx < 0,
              (bad_idx < 0) ? 0 : int'(mem[bad_idx]), (bad_idx < 0) ? 0 : int'(mdl[bad_idx]));
        check({tag, " R5 read count"}, rd_cnt == e_rd, rd_cnt, e_rd);
        check({tag, " R9 write count"}, wr_cnt == e_wr, wr_cnt, e_wr);
        // R11: idle after halt, request toggled
        r0 = rd_cnt; w0 = wr_cnt;
        for (int i = 0; i < 8; i++) begin
            irq = ~irq;
            @(negedge clk);
        end
        check({tag, " R11 silent after halt"}, rd_cnt == r0 && wr_cnt == w0 && halted,
              rd_cnt + wr_cnt, r0 + w0);
    endtask

    initial begin
        fork
            begin
                // T1: direct load/add/store (R3, R4, R6)
                clear_all();
                put(0, ins(0, 3'd0, 'h40)); put(1, ins(0, 3'd2, 'h41));
                put(2, ins(0, 3'd1, 'h42)); put(3, ins(0, 3'd7, 0));
                put('h40, 16'd5); put('h41, 16'd7);
                run("direct", 1'b0);
                check("R6 store result", mem['h42] == 16'd12, mem['h42], 12);

                // T2: indirect with junk upper bits in pointer (R5)
                clear_all();
                put(0, ins(1, 3'd0, 'h80)); put(1, ins(1, 3'd1, 'h81));
                put(2, ins(0, 3'd7, 0));
                put('h80, 16'hA041); put('h81, 16'h5050); put('h41, 16'h1234);
                run("indirect", 1'b0);
                check("R5 indirect store target", mem['h50] == 16'h1234, mem['h50], 'h1234);

                // T3: add wraps modulo 2^16 (R6), no-op codes (R3)
                clear_all();
                put(0, ins(0, 3'd0, 'h40)); put(1, ins(0, 3'd4, 'h41));
                put(2, ins(0, 3'd5, 'h42)); put(3, ins(0, 3'd6, 'h43));
                put(4, ins(0, 3'd2, 'h41)); put(5, ins(0, 3'd7, 0));
                put('h40, 16'hFFFF); put('h41, 16'd2);
                run("wrap_nop", 1'b0);
                check("R3 R6 wrap result", acc == 16'd1, acc, 1);

                // T4: interrupt after the instruction following enable (R9, R10)
                clear_all();
                put(0, ins(0, 3'd3, 0)); put(1, ins(0, 3'd0, 'h40));
                put(2, ins(0, 3'd2, 'h41)); put(3, ins(0, 3'd7, 0));
                put(HNDL, ins(0, 3'd1, 'h60)); put(HNDL + 1, ins(0, 3'd7, 0));
                put('h40, 16'd9); put('h41, 16'd1);
                run("interrupt", 1'b1);
                check("R9 R10 saved return address", mem[SAVE] == 16'd2, mem[SAVE], 2);
                check("R9 handler ran", mem['h60] == 16'd9, mem['h60], 9);

                // T5: request high without enable is ignored (R8)
                clear_all();
                put(0, ins(0, 3'd0, 'h40)); put(1, ins(0, 3'd1, 'h41));
                put(2, ins(0, 3'd7, 0)); put('h40, 16'h00AB);
                run("masked", 1'b1);
                check("R8 no save written", mem[SAVE] == 16'h0, mem[SAVE], 0);

                // Random programs
                void'($urandom(32'd1357));
                for (int t = 0; t < 30; t++) begin
                    logic lvl;
                    clear_all();
                    for (int i = 0; i < 24; i++) begin
                        logic ind = 1'($urandom_range(0, 1));
                        int   op  = $urandom_range(0, 6);
                        int   a   = ind ? $urandom_range('h80, 'h9F) : $urandom_range('h40, 'h7F);
                        put(i, ins(ind, 3'(op), a));
                    end
                    put(24, ins(0, 3'd7, 0));
                    for (int i = 'h40; i < 'h80; i++) put(i, 16'($urandom()));
                    for (int i = 'h80; i < 'hA0; i++)
                        put(i, {4'($urandom()), 12'($urandom_range('h40, 'h7F))});
                    put(HNDL, ins(0, 3'd1, 'h60)); put(HNDL + 1, ins(0, 3'd7, 0));
                    lvl = 1'($urandom_range(0, 1));
                    run($sformatf("rand%0d", t), lvl);
                end
            end
            begin
                repeat (190000) @(posedge clk);
                wd_expired = 1'b1;
            end
        join_any
        disable fork;
        check("watchdog", !wd_expired, wd_expired, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule